// File: doc/BRIEF.md
# Vector Length State Register

This unit keeps the loop-length context of a vectorising scalar core in one packed 30-bit word. The word holds the largest permitted vector length, the active vector length, the sub-vector group size and the four element offsets that a running element loop stores so it can be resumed. Every length is kept minus one, so six bits reach every length from 1 to 64.

Software changes the context through one write port. A write can request a new active length, request a new maximum length, or load the whole word, either for the live copy or for the shadow copy that is kept for trap handling. Requested lengths are clamped as they arrive, so the stored active length is never zero and never larger than the maximum. A trap-entry or trap-return strobe swaps the live word with the shadow word in a single cycle. The read port returns one of four views of the current register contents without any added latency.

Top module: `vl_state_reg`

## Requirements
- R1: While rst_ni is low and after it rises, the maximum length, the active length and the group size all read as 1, every offset is zero, and both raw words (live and shadow) read as 0.
- R2: The raw live word, read with rd_sel_i = 2, packs the maximum length minus one in bits 5:0, the active length minus one in bits 11:6, the source offset in 17:12, the destination offset in 23:18, the group size minus one in 25:24, the source sub-offset in 27:26 and the destination sub-offset in 29:28. Bits 63:30 read as zero.
- R3: A write with wr_sel_i = 0 sets the active length to the lesser of wr_data_i and the maximum length. Other fields do not change, and a read with rd_sel_i = 0 returns the resulting length from the next cycle.
- R4: A requested length of 0, whether for the active length or for the maximum, is stored as a length of 1.
- R5: A write with wr_sel_i = 1 sets the maximum length to the lesser of wr_data_i and 64. If the active length is larger than the new maximum, it drops to the new maximum on the same edge. The active length never exceeds the maximum.
- R6: A write with wr_sel_i = 2 loads the live word from wr_data_i[29:0] and ignores bits 63:30. If the loaded active field is larger than the loaded maximum field, the active field is stored equal to the maximum field.
- R7: A write with wr_sel_i = 3 loads the shadow word from wr_data_i[29:0] under the same clamping as R6, and leaves the live word unchanged.
- R8: When trap_enter_i or trap_return_i is high (or both are), the live and shadow words are exchanged on that edge. Any write in the same cycle is ignored.
- R9: rd_sel_i selects the read view: 0 returns the active length, 1 returns the maximum length, 2 returns the live word and 3 returns the shadow word. All views are zero-extended to 64 bits.
- R10: With no write and no trap strobe, both words hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 active length, 1 maximum length, 2 live word, 3 shadow word |
| wr_data_i | input | 64 | Requested length or raw word |
| trap_enter_i | input | 1 | Swap strobe on trap entry |
| trap_return_i | input | 1 | Swap strobe on trap return |
| rd_sel_i | input | 2 | Read view select |
| rd_data_o | output | 64 | Selected view, zero-extended |

## Verification
The bench focuses on the edges of the length encoding. A request of zero must give length 1, not wrap to 64. A request of exactly 64, or of any value above it, must give 64 and must not be truncated modulo 64. Lowering the maximum below the active length must pull the active length down on the same edge, or the active length would be left out of range. A raw word whose active field is larger than its maximum field must be clamped, and a raw write with upper bits set must not touch any field. Trap strobes arriving together with writes must leave the write ignored. Both strobes at once must swap the words only once, since a double swap would undo the exchange.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int XLEN    = 64;
  localparam int LEN_W   = $clog2(XLEN);
  localparam int SUB_W   = 2;
  localparam int STATE_W = 4 * LEN_W + 3 * SUB_W;

  typedef enum logic [1:0] {
    SEL_VL     = 2'd0,
    SEL_MVL    = 2'd1,
    SEL_STATE  = 2'd2,
    SEL_SHADOW = 2'd3
  } vls_sel_e;

  // Field order fixes the packed bit positions (MSB first).
  typedef struct packed {
    logic [SUB_W-1:0] dst_sub;
    logic [SUB_W-1:0] src_sub;
    logic [SUB_W-1:0] grp_m1;
    logic [LEN_W-1:0] dst_off;
    logic [LEN_W-1:0] src_off;
    logic [LEN_W-1:0] vl_m1;
    logic [LEN_W-1:0] mvl_m1;
  } vls_state_t;

  function automatic vls_state_t fit_vl(input vls_state_t s);
    vls_state_t r;
    r = s;
    if (s.vl_m1 > s.mvl_m1) r.vl_m1 = s.mvl_m1;
    return r;
  endfunction
endpackage

// File: rtl/vls_len_clamp.sv
module vls_len_clamp #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 6
) (
  input  logic [XLEN-1:0]  req_i,
  input  logic [LEN_W-1:0] limit_m1_i,
  output logic [LEN_W-1:0] len_m1_o
);
  logic [XLEN-1:0] req_m1;

  assign req_m1 = req_i - XLEN'(1);

  always_comb begin
    if (req_i == '0)
      len_m1_o = '0;
    else if (req_m1 > XLEN'(limit_m1_i))
      len_m1_o = limit_m1_i;
    else
      len_m1_o = req_m1[LEN_W-1:0];
  end
endmodule

// File: rtl/vls_next.sv
module vls_next
  import vls_pkg::*;
#(
  parameter int XLEN = vls_pkg::XLEN
) (
  input  vls_state_t      state_i,
  input  vls_state_t      shadow_i,
  input  logic            swap_i,
  input  logic            wr_en_i,
  input  vls_sel_e        wr_sel_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [LEN_W-1:0] vl_req_m1_i,
  input  logic [LEN_W-1:0] mvl_req_m1_i,
  output vls_state_t      state_o,
  output vls_state_t      shadow_o
);
  vls_state_t raw;

  assign raw = fit_vl(vls_state_t'(wr_data_i[STATE_W-1:0]));

  always_comb begin
    state_o  = state_i;
    shadow_o = shadow_i;
    if (swap_i) begin
      state_o  = shadow_i;
      shadow_o = state_i;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_VL:  state_o.vl_m1 = vl_req_m1_i;
        SEL_MVL: begin
          state_o.mvl_m1 = mvl_req_m1_i;
          if (state_i.vl_m1 > mvl_req_m1_i) state_o.vl_m1 = mvl_req_m1_i;
        end
        SEL_STATE:  state_o  = raw;
        SEL_SHADOW: shadow_o = raw;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vls_rd_mux.sv
module vls_rd_mux
  import vls_pkg::*;
#(
  parameter int XLEN = vls_pkg::XLEN
) (
  input  vls_state_t      state_i,
  input  vls_state_t      shadow_i,
  input  vls_sel_e        sel_i,
  output logic [XLEN-1:0] data_o
);
  logic [LEN_W:0] vl_len, mvl_len;

  assign vl_len  = {1'b0, state_i.vl_m1}  + (LEN_W+1)'(1);
  assign mvl_len = {1'b0, state_i.mvl_m1} + (LEN_W+1)'(1);

  always_comb begin
    unique case (sel_i)
      SEL_VL:     data_o = XLEN'(vl_len);
      SEL_MVL:    data_o = XLEN'(mvl_len);
      SEL_STATE:  data_o = XLEN'(state_i);
      SEL_SHADOW: data_o = XLEN'(shadow_i);
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/vl_state_reg.sv
module vl_state_reg
  import vls_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            trap_enter_i,
  input  logic            trap_return_i,
  input  logic [1:0]      rd_sel_i,
  output logic [XLEN-1:0] rd_data_o
);
  vls_state_t state_q, shadow_q, state_d, shadow_d;
  logic [LEN_W-1:0] vl_req_m1, mvl_req_m1;
  logic swap;
  vls_sel_e wsel;

  assign swap = trap_enter_i | trap_return_i;
  assign wsel = vls_sel_e'(wr_sel_i);

  vls_len_clamp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_vl_clamp (
    .req_i      (wr_data_i),
    .limit_m1_i (state_q.mvl_m1),
    .len_m1_o   (vl_req_m1)
  );

  vls_len_clamp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_mvl_clamp (
    .req_i      (wr_data_i),
    .limit_m1_i ({LEN_W{1'b1}}),
    .len_m1_o   (mvl_req_m1)
  );

  vls_next #(.XLEN(XLEN)) u_next (
    .state_i      (state_q),
    .shadow_i     (shadow_q),
    .swap_i       (swap),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wsel),
    .wr_data_i    (wr_data_i),
    .vl_req_m1_i  (vl_req_m1),
    .mvl_req_m1_i (mvl_req_m1),
    .state_o      (state_d),
    .shadow_o     (shadow_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= '0;
      shadow_q <= '0;
    end else begin
      state_q  <= state_d;
      shadow_q <= shadow_d;
    end
  end

  vls_rd_mux #(.XLEN(XLEN)) u_rd (
    .state_i  (state_q),
    .shadow_i (shadow_q),
    .sel_i    (vls_sel_e'(rd_sel_i)),
    .data_o   (rd_data_o)
  );

  // R5
  vl_within_mvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q.vl_m1 <= state_q.mvl_m1);

  // R8
  trap_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |=> (state_q == $past(shadow_q)) && (shadow_q == $past(state_q)));

  // R3
  vl_write_keeps_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !swap && wsel == SEL_VL) |=>
      (state_q.mvl_m1 == $past(state_q.mvl_m1)) && (state_q.src_off == $past(state_q.src_off))
      && (state_q.dst_off == $past(state_q.dst_off)) && $stable(shadow_q));

  // R5
  mvl_write_no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !swap && wsel == SEL_MVL) |=> state_q.vl_m1 <= $past(state_q.vl_m1));

  // R7
  shadow_write_keeps_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !swap && wsel == SEL_SHADOW) |=> $stable(state_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !swap) |=> $stable(state_q) && $stable(shadow_q));
endmodule

// File: tb/vl_state_reg_bench.sv
`timescale 1ns/1ps
module vl_state_reg_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [63:0] wr_data_i = '0;
  logic        trap_enter_i = 1'b0;
  logic        trap_return_i = 1'b0;
  logic [1:0]  rd_sel_i = 2'd0;
  logic [63:0] rd_data_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [29:0] m_live = '0;
  logic [29:0] m_shad = '0;

  always #2.5 clk_i = ~clk_i;

  vl_state_reg u_vl_state_reg (.*);

  function automatic logic [5:0] len_enc(input logic [63:0] req, input logic [5:0] lim);
    if (req == 0) return 6'd0;
    if (req - 64'd1 > {58'd0, lim}) return lim;
    return 6'(req - 64'd1);
  endfunction

  function automatic logic [29:0] fit(input logic [29:0] w);
    logic [29:0] r = w;
    if (w[11:6] > w[5:0]) r[11:6] = w[5:0];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    rd_sel_i = 2'd0; #0.1; check({req, " R9 vl view"}, rd_data_o, 64'(m_live[11:6]) + 64'd1);
    rd_sel_i = 2'd1; #0.1; check({req, " R9 mvl view"}, rd_data_o, 64'(m_live[5:0]) + 64'd1);
    rd_sel_i = 2'd2; #0.1; check({req, " R2 live word"}, rd_data_o, 64'(m_live));
    rd_sel_i = 2'd3; #0.1; check({req, " R9 shadow word"}, rd_data_o, 64'(m_shad));
  endtask

  task automatic op(input bit we, input logic [1:0] sel, input logic [63:0] d,
                    input bit te, input bit tr, input string req);
    logic [29:0] nl, ns;
    @(negedge clk_i);
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d; trap_enter_i = te; trap_return_i = tr;
    nl = m_live; ns = m_shad;
    if (te || tr) begin nl = m_shad; ns = m_live; end
    else if (we) begin
      case (sel)
        2'd0: nl[11:6] = len_enc(d, m_live[5:0]);
        2'd1: begin
          nl[5:0] = len_enc(d, 6'h3f);
          if (m_live[11:6] > nl[5:0]) nl[11:6] = nl[5:0];
        end
        2'd2: nl = fit(d[29:0]);
        default: ns = fit(d[29:0]);
      endcase
    end
    @(posedge clk_i);
    m_live = nl; m_shad = ns;
    @(negedge clk_i);
    wr_en_i = 1'b0; trap_enter_i = 1'b0; trap_return_i = 1'b0;
    #0.2;
    check_all(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_ed01));
    #3.1;
    check_all("R1 in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    #0.2;
    check_all("R1 after reset");
    // directed corners
    op(1, 2'd0, 64'd5, 0, 0, "R3 vl above mvl=1");
    op(1, 2'd1, 64'd100, 0, 0, "R5 mvl above 64");
    op(1, 2'd0, 64'd64, 0, 0, "R3 vl=64");
    op(1, 2'd0, 64'd0, 0, 0, "R4 vl req 0");
    op(1, 2'd0, 64'd40, 0, 0, "R3 vl 40");
    op(1, 2'd1, 64'd10, 0, 0, "R5 mvl below vl");
    op(1, 2'd1, 64'd0, 0, 0, "R4 mvl req 0");
    op(1, 2'd1, 64'd64, 0, 0, "R5 mvl 64");
    op(1, 2'd0, 64'hffff_ffff_ffff_ffff, 0, 0, "R3 vl huge req");
    op(1, 2'd2, {34'h3_ffff_ffff, 30'h3abc_f7c5}, 0, 0, "R6 raw clamp upper ignored");
    op(1, 2'd3, 64'h0000_0000_1234_5678, 0, 0, "R7 shadow write");
    op(1, 2'd1, 64'd3, 1, 0, "R8 enter with write");
    op(0, 2'd0, 64'd0, 0, 1, "R8 return");
    op(1, 2'd2, 64'd0, 1, 1, "R8 both strobes");
    op(0, 2'd2, 64'h3fff_ffff, 0, 0, "R10 idle");
    // random
    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      logic [1:0] s = 2'($urandom);
      int k = $urandom % 4;
      if (k == 0) d = {$urandom, $urandom};
      else if (k == 1) d = 64'($urandom % 4);
      else d = 64'($urandom % 72);
      op(($urandom % 5) != 0, s, d, ($urandom % 10) == 0, ($urandom % 12) == 0, "R3-R10 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule